// File: doc/BRIEF.md
# Downstream Attach and Speed Detector

This block sits in an isolated bus bridge. On the downstream side it watches the debounced idle levels of the two data lines and sorts the attached device into one of three classes: full speed, low speed or nothing attached. It does not send a message only when the class changes. Instead it sends the current class over the isolation link as a refresh message at a fixed rate.

On the upstream side, a small state machine turns the received class into two switch enables. One enable connects a pull-up to the positive data line and the other connects a pull-up to the negative data line. A change of class is only accepted once it has arrived on several refreshes in a row. This rejects glitches. While downstream packet traffic is running, classification is frozen, and it is updated only during idle.

A second state machine measures how long the upstream bus has been idle and places the block in suspend. While suspended, the pull-up setting is held. Any change of data state wakes the block. A third machine filters the pins' over-current flag so that only a lasting fault disables the pin.

Top module: `attach_speed_monitor`

State machines:
- **Pull-up state machine.** States `PU_OPEN`, `PU_FULL` and `PU_LOW`. The transition to the state matching a new class is taken when the refresh carrying that class completes the confirmation count.
- **Suspend state machine.** States `SU_RUN` and `SU_SLEEP`.
  - `SU_RUN` to `SU_SLEEP` on the idle limit.
  - `SU_SLEEP` to `SU_RUN` on a wake event.
- **Fault filter.** States `F_OK`, `F_PEND` and `F_TRIP`.
  - `F_OK` to `F_PEND` when the over-current flag rises.
  - `F_PEND` back to `F_OK` when the flag drops.
  - `F_PEND` to `F_TRIP` when the flag has persisted.
  - `F_TRIP` is held until reset.

## Requirements
- R1: Idle levels with the positive line high and the negative line low are classified full speed (message code 1). Once confirmed, this drives `up_dp_pu_en`=1 and `up_dm_pu_en`=0.
- R2: Idle levels with the negative line high and the positive line low are classified low speed (message code 2). Once confirmed, this drives `up_dm_pu_en`=1 and `up_dp_pu_en`=0.
- R3: Both lines low, or both lines high, are classified disconnected (message code 0). Once confirmed, this drives both enables to 0. The two enables are never 1 together.
- R4: `refresh_stb` pulses for one cycle every `REFRESH_CYC` cycles, whether or not the class has changed. `refresh_msg` carries the class on every pulse.
- R5: The enables change only in the cycle after a refresh pulse. A new class takes effect on the `CONFIRM_CNT`-th consecutive refresh that carries it. A refresh carrying the currently applied class cancels any pending change.
- R6: While `dn_busy` is 1, the classification keeps the value it had in the last cycle before busy began, whatever the line levels do.
- R7: `suspended` rises after more than `SUSP_CYC` consecutive cycles with `up_activity` at 0. A single cycle of `up_activity` restarts the count.
- R8: While `suspended` is 1, the pull-up enables do not change, and refreshes are not counted toward a change.
- R9: From suspend, `suspended` falls in the cycle after any of three events: `up_activity`, `dn_busy`, or a refresh whose class differs from the applied one. The refresh that causes the wake does not count toward confirmation.
- R10: `pin_off` sets only after `pin_oc` has been 1 for more than `FAULT_HOLD_CYC` consecutive cycles. A shorter burst leaves it at 0. Once set, `pin_off` stays at 1 until reset.
- R11: After reset, both enables, `suspended`, `pin_off` and `refresh_stb` are 0, and `refresh_msg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dn_dp_idle | input | 1 | Debounced downstream positive-line idle level |
| dn_dm_idle | input | 1 | Debounced downstream negative-line idle level |
| dn_busy | input | 1 | Downstream packet in progress |
| up_activity | input | 1 | Upstream line activity seen this cycle |
| pin_oc | input | 1 | Raw pin over-current flag |
| up_dp_pu_en | output | 1 | Enable for the upstream positive-line pull-up switch |
| up_dm_pu_en | output | 1 | Enable for the upstream negative-line pull-up switch |
| suspended | output | 1 | Block is in suspend |
| refresh_stb | output | 1 | Refresh message strobe |
| refresh_msg | output | 2 | Refresh class: 0 none, 1 full, 2 low |
| pin_off | output | 1 | Qualified over-current fault, pin disabled |

## Verification
The classifier is driven with each of the four idle line combinations. This separates full speed, low speed and the two forms of disconnect, which are checked both at the message and at the enables. Several refresh patterns are applied:
- a change held for one refresh and then reverted, which must leave the enables untouched;
- a change held through the confirmation count;
- line changes made while busy, which must not reach the message until busy ends.

Idle runs ending one cycle short of the suspend limit and exactly at it are applied, as are fault bursts one cycle short of the persistence limit and exactly at it. Wake from suspend is tried separately through upstream activity, downstream busy and a downstream disconnect.

// File: rtl/asm_pkg.sv
package asm_pkg;
    typedef enum logic [1:0] {
        ATT_NONE = 2'd0,
        ATT_FULL = 2'd1,
        ATT_LOW  = 2'd2
    } attach_e;
endpackage

// File: rtl/asm_line_sense.sv
module asm_line_sense
    import asm_pkg::*;
#(
    parameter int REFRESH_CYC = 64
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dp_idle,
    input  logic    dm_idle,
    input  logic    busy,
    output logic    refresh_stb,
    output attach_e msg
);
    localparam int TW = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(REFRESH_CYC - 1);

    logic [TW-1:0] tmr_q;
    attach_e       cls_now;
    attach_e       cls_q;

    always_comb begin
        unique case ({dp_idle, dm_idle})
            2'b10:   cls_now = ATT_FULL;
            2'b01:   cls_now = ATT_LOW;
            default: cls_now = ATT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q <= ATT_NONE;
            tmr_q <= '0;
        end else begin
            if (!busy) cls_q <= cls_now;
            tmr_q <= (tmr_q == LAST) ? '0 : tmr_q + 1'b1;
        end
    end

    assign refresh_stb = (tmr_q == LAST);
    assign msg         = cls_q;
endmodule

// File: rtl/asm_pullup_ctrl.sv
module asm_pullup_ctrl
    import asm_pkg::*;
#(
    parameter int CONFIRM_CNT = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    refresh_stb,
    input  attach_e msg,
    input  logic    hold,
    output logic    dp_en,
    output logic    dm_en,
    output attach_e applied
);
    localparam int CW = $clog2(CONFIRM_CNT + 1);
    localparam logic [CW-1:0] NEED = CW'(CONFIRM_CNT);

    typedef enum logic [1:0] {PU_OPEN, PU_FULL, PU_LOW} pu_state_e;

    pu_state_e     st_q, st_d;
    attach_e       cand_q, cand_d;
    logic [CW-1:0] seen_q, seen_d, nseen;

    function automatic pu_state_e state_of(attach_e a);
        unique case (a)
            ATT_FULL: return PU_FULL;
            ATT_LOW:  return PU_LOW;
            default:  return PU_OPEN;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PU_OPEN;
            cand_q <= ATT_NONE;
            seen_q <= '0;
        end else begin
            st_q   <= st_d;
            cand_q <= cand_d;
            seen_q <= seen_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cand_d = cand_q;
        seen_d = seen_q;
        nseen  = (msg == cand_q && seen_q != '0) ? seen_q + 1'b1 : CW'(1);
        if (refresh_stb && !hold) begin
            if (msg == applied) begin
                seen_d = '0;
            end else if (nseen >= NEED) begin
                st_d   = state_of(msg);
                seen_d = '0;
            end else begin
                cand_d = msg;
                seen_d = nseen;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            PU_FULL: begin dp_en = 1'b1; dm_en = 1'b0; applied = ATT_FULL; end
            PU_LOW:  begin dp_en = 1'b0; dm_en = 1'b1; applied = ATT_LOW;  end
            default: begin dp_en = 1'b0; dm_en = 1'b0; applied = ATT_NONE; end
        endcase
    end
endmodule

// File: rtl/asm_suspend_fsm.sv
module asm_suspend_fsm
    import asm_pkg::*;
#(
    parameter int SUSP_CYC = 375000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    up_activity,
    input  logic    dn_busy,
    input  logic    refresh_stb,
    input  attach_e msg,
    input  attach_e applied,
    output logic    suspended
);
    localparam int IW = $clog2(SUSP_CYC + 1);
    localparam logic [IW-1:0] LIM = IW'(SUSP_CYC);

    typedef enum logic {SU_RUN, SU_SLEEP} su_state_e;

    su_state_e     st_q, st_d;
    logic [IW-1:0] idle_q, idle_d;
    logic          wake;

    assign wake = up_activity || dn_busy || (refresh_stb && msg != applied);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SU_RUN;
            idle_q <= '0;
        end else begin
            st_q   <= st_d;
            idle_q <= idle_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        idle_d = idle_q;
        unique case (st_q)
            SU_RUN: begin
                if (up_activity) begin
                    idle_d = '0;
                end else if (idle_q == LIM) begin
                    st_d   = SU_SLEEP;
                    idle_d = '0;
                end else begin
                    idle_d = idle_q + 1'b1;
                end
            end
            SU_SLEEP: begin
                if (wake) begin
                    st_d   = SU_RUN;
                    idle_d = '0;
                end
            end
            default: st_d = SU_RUN;
        endcase
    end

    always_comb suspended = (st_q == SU_SLEEP);
endmodule

// File: rtl/asm_fault_filter.sv
module asm_fault_filter #(
    parameter int HOLD_CYC = 75
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc,
    output logic tripped
);
    localparam int FW = $clog2(HOLD_CYC + 1);
    localparam logic [FW-1:0] LIM = FW'(HOLD_CYC);

    typedef enum logic [1:0] {F_OK, F_PEND, F_TRIP} flt_state_e;

    flt_state_e    st_q, st_d;
    logic [FW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_OK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            F_OK: if (oc) begin st_d = F_PEND; cnt_d = FW'(1); end
            F_PEND: begin
                if (!oc) begin
                    st_d  = F_OK;
                    cnt_d = '0;
                end else if (cnt_q == LIM) begin
                    st_d = F_TRIP;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            F_TRIP:  st_d = F_TRIP;
            default: st_d = F_OK;
        endcase
    end

    always_comb tripped = (st_q == F_TRIP);
endmodule

// File: rtl/attach_speed_monitor.sv
module attach_speed_monitor
    import asm_pkg::*;
#(
    parameter int REFRESH_CYC    = 64,
    parameter int CONFIRM_CNT    = 2,
    parameter int SUSP_CYC       = 375000,
    parameter int FAULT_HOLD_CYC = 75
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dn_dp_idle,
    input  logic       dn_dm_idle,
    input  logic       dn_busy,
    input  logic       up_activity,
    input  logic       pin_oc,
    output logic       up_dp_pu_en,
    output logic       up_dm_pu_en,
    output logic       suspended,
    output logic       refresh_stb,
    output logic [1:0] refresh_msg,
    output logic       pin_off
);
    attach_e msg_w;
    attach_e applied_w;

    asm_line_sense #(.REFRESH_CYC(REFRESH_CYC)) u_sense (
        .clk(clk), .rst_n(rst_n), .dp_idle(dn_dp_idle), .dm_idle(dn_dm_idle),
        .busy(dn_busy), .refresh_stb(refresh_stb), .msg(msg_w)
    );

    asm_pullup_ctrl #(.CONFIRM_CNT(CONFIRM_CNT)) u_pullup (
        .clk(clk), .rst_n(rst_n), .refresh_stb(refresh_stb), .msg(msg_w),
        .hold(suspended), .dp_en(up_dp_pu_en), .dm_en(up_dm_pu_en),
        .applied(applied_w)
    );

    asm_suspend_fsm #(.SUSP_CYC(SUSP_CYC)) u_susp (
        .clk(clk), .rst_n(rst_n), .up_activity(up_activity), .dn_busy(dn_busy),
        .refresh_stb(refresh_stb), .msg(msg_w), .applied(applied_w),
        .suspended(suspended)
    );

    asm_fault_filter #(.HOLD_CYC(FAULT_HOLD_CYC)) u_fault (
        .clk(clk), .rst_n(rst_n), .oc(pin_oc), .tripped(pin_off)
    );

    assign refresh_msg = msg_w;
endmodule

// File: rtl/attach_speed_monitor_chk.sv
module attach_speed_monitor_chk #(
    parameter int REFRESH_CYC = 64
) (
    input logic clk,
    input logic rst_n,
    input logic up_activity,
    input logic pin_oc,
    input logic up_dp_pu_en,
    input logic up_dm_pu_en,
    input logic suspended,
    input logic refresh_stb,
    input logic pin_off
);
    localparam int GW = $clog2(REFRESH_CYC + 1);
    localparam logic [GW-1:0] GLAST = GW'(REFRESH_CYC - 1);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)           gap_q <= '0;
        else if (refresh_stb) gap_q <= '0;
        else                  gap_q <= gap_q + 1'b1;
    end

    assert_pu_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_dp_pu_en, up_dm_pu_en}));

    assert_refresh_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb == (gap_q == GLAST));

    assert_pu_moves_on_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_stb |=> $stable({up_dp_pu_en, up_dm_pu_en}));

    assert_sleep_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> !$past(up_activity));

    assert_hold_in_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> $stable({up_dp_pu_en, up_dm_pu_en}));

    assert_wake_on_activity_R9: assert property (@(posedge clk) disable iff (!rst_n)
        up_activity |=> !suspended);

    assert_trip_needs_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_off) |-> $past(pin_oc));

    assert_trip_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_off |=> pin_off);
endmodule

bind attach_speed_monitor attach_speed_monitor_chk #(.REFRESH_CYC(REFRESH_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .up_activity(up_activity), .pin_oc(pin_oc),
    .up_dp_pu_en(up_dp_pu_en), .up_dm_pu_en(up_dm_pu_en), .suspended(suspended),
    .refresh_stb(refresh_stb), .pin_off(pin_off)
);

// File: tb/attach_speed_monitor_bench.sv
`timescale 1ns/1ps
module attach_speed_monitor_bench;
    localparam int REFRESH_CYC = 16;
    localparam int CONFIRM_CNT = 2;
    localparam int SUSP_CYC    = 300;
    localparam int FAULT_CYC   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dp = 1'b0, dm = 1'b0, busy = 1'b0, act = 1'b1, oc = 1'b0;
    logic dp_en, dm_en, susp, stb, pin_off;
    logic [1:0] msg;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    attach_speed_monitor #(
        .REFRESH_CYC(REFRESH_CYC), .CONFIRM_CNT(CONFIRM_CNT),
        .SUSP_CYC(SUSP_CYC), .FAULT_HOLD_CYC(FAULT_CYC)
    ) u_attach_speed_monitor (
        .clk(clk), .rst_n(rst_n), .dn_dp_idle(dp), .dn_dm_idle(dm),
        .dn_busy(busy), .up_activity(act), .pin_oc(oc),
        .up_dp_pu_en(dp_en), .up_dm_pu_en(dm_en), .suspended(susp),
        .refresh_stb(stb), .refresh_msg(msg), .pin_off(pin_off)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic check_pu(string tag, int exp_dp, int exp_dm);
        check({tag, " dp_en"}, int'(dp_en), exp_dp);
        check({tag, " dm_en"}, int'(dm_en), exp_dm);
    endtask

    task automatic set_lines(logic p, logic m);
        dp = p; dm = m;
        @(negedge clk);
    endtask

    task automatic wait_strobe();
        while (!stb) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R11 dp_en", int'(dp_en), 0);
        check("R11 dm_en", int'(dm_en), 0);
        check("R11 suspended", int'(susp), 0);
        check("R11 pin_off", int'(pin_off), 0);
        check("R11 strobe", int'(stb), 0);
        check("R11 msg", int'(msg), 0);
    endtask

    task automatic t_refresh_period();
        int n = 1;
        wait_strobe();
        while (!stb) begin @(negedge clk); n++; end
        check("R4 period", n, REFRESH_CYC);
        check("R4 msg unchanged class", int'(msg), 0);
    endtask

    task automatic t_full();
        set_lines(1'b1, 1'b0);
        check("R1 msg code", int'(msg), 1);
        wait_strobe();
        check_pu("R5 one refresh not enough", 0, 0);
        wait_strobe();
        check_pu("R1 full speed", 1, 0);
    endtask

    task automatic t_low();
        set_lines(1'b0, 1'b1);
        check("R2 msg code", int'(msg), 2);
        wait_strobe();
        wait_strobe();
        check_pu("R2 low speed", 0, 1);
    endtask

    task automatic t_disconnect();
        set_lines(1'b1, 1'b1);
        check("R3 both high msg", int'(msg), 0);
        wait_strobe();
        wait_strobe();
        check_pu("R3 both high released", 0, 0);
        set_lines(1'b1, 1'b0);
        wait_strobe();
        wait_strobe();
        check_pu("R1 reconnect full", 1, 0);
        set_lines(1'b0, 1'b0);
        check("R3 both low msg", int'(msg), 0);
        wait_strobe();
        wait_strobe();
        check_pu("R3 both low released", 0, 0);
    endtask

    task automatic t_glitch();
        set_lines(1'b1, 1'b0);
        wait_strobe();
        wait_strobe();
        set_lines(1'b0, 1'b1);
        wait_strobe();
        set_lines(1'b1, 1'b0);
        wait_strobe();
        wait_strobe();
        check_pu("R5 single-refresh glitch ignored", 1, 0);
        set_lines(1'b0, 1'b1);
        wait_strobe();
        check_pu("R5 pending not applied", 1, 0);
        wait_strobe();
        check_pu("R5 confirmed change", 0, 1);
    endtask

    task automatic t_busy();
        set_lines(1'b1, 1'b0);
        wait_strobe();
        wait_strobe();
        busy = 1'b1;
        @(negedge clk);
        set_lines(1'b0, 1'b1);
        check("R6 msg frozen", int'(msg), 1);
        wait_strobe();
        wait_strobe();
        wait_strobe();
        check_pu("R6 no change while busy", 1, 0);
        busy = 1'b0;
        @(negedge clk);
        check("R6 msg after busy", int'(msg), 2);
        wait_strobe();
        wait_strobe();
        check_pu("R6 update after busy", 0, 1);
    endtask

    task automatic t_suspend();
        set_lines(1'b1, 1'b0);
        wait_strobe();
        wait_strobe();
        act = 1'b0;
        repeat (SUSP_CYC) @(negedge clk);
        check("R7 not yet suspended", int'(susp), 0);
        act = 1'b1;
        @(negedge clk);
        act = 1'b0;
        repeat (SUSP_CYC) @(negedge clk);
        check("R7 count restarted", int'(susp), 0);
        @(negedge clk);
        check("R7 suspended", int'(susp), 1);
        wait_strobe();
        wait_strobe();
        wait_strobe();
        check("R8 still suspended", int'(susp), 1);
        check_pu("R8 pull-up held", 1, 0);
    endtask

    task automatic t_wake_activity();
        act = 1'b1;
        @(negedge clk);
        check("R9 wake by activity", int'(susp), 0);
        act = 1'b0;
        repeat (SUSP_CYC + 1) @(negedge clk);
        check("R7 re-entered", int'(susp), 1);
    endtask

    task automatic t_wake_disconnect();
        set_lines(1'b0, 1'b0);
        check("R9 asleep before refresh", int'(susp), 1);
        wait_strobe();
        act = 1'b1;
        check("R9 wake by disconnect", int'(susp), 0);
        check_pu("R9 waking refresh not counted", 1, 0);
        wait_strobe();
        check_pu("R9 one refresh after wake", 1, 0);
        wait_strobe();
        check_pu("R9 released after wake", 0, 0);
    endtask

    task automatic t_wake_busy();
        act = 1'b0;
        repeat (SUSP_CYC + 1) @(negedge clk);
        check("R7 asleep again", int'(susp), 1);
        busy = 1'b1;
        @(negedge clk);
        check("R9 wake by downstream busy", int'(susp), 0);
        busy = 1'b0;
        act = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_fault();
        oc = 1'b1;
        repeat (FAULT_CYC) @(negedge clk);
        oc = 1'b0;
        @(negedge clk);
        check("R10 short burst ignored", int'(pin_off), 0);
        oc = 1'b1;
        repeat (FAULT_CYC) @(negedge clk);
        check("R10 not tripped at limit", int'(pin_off), 0);
        @(negedge clk);
        check("R10 tripped", int'(pin_off), 1);
        oc = 1'b0;
        repeat (5) @(negedge clk);
        check("R10 latched", int'(pin_off), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refresh_period();
        t_full();
        t_low();
        t_disconnect();
        t_glitch();
        t_busy();
        t_suspend();
        t_wake_activity();
        t_wake_disconnect();
        t_wake_busy();
        t_fault();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule